// File: doc/BRIEF.md
# Supply reset and sleep supervisor

This block is the digital supervisor that sits beside a low-dropout regulator with a processor watchdog. From a filtered power-good comparator result, an external enable line and the two flags of a watchdog period monitor (in window, fault), it produces an active-low reset for the processor and an enable for the regulator output stage. All of its timing is derived from one base unit of `UNIT_TICKS` clock cycles. The power-on delay is 47.5 base units. The reset pulse train shown while the watchdog misbehaves uses phases of one base unit.

The processor is held in reset while power comes up and for the power-on delay afterwards. Short undervoltage dips are filtered out. A longer dip restarts the whole delay. If the watchdog leaves its window, reset toggles until valid kicks return. If the enable line is low when the watchdog faults, the supervisor switches the output stage off and sleeps. A later rising edge on enable wakes it with a fresh power-on sequence. This lets a processor finish its shutdown work and then power itself down by stopping its watchdog kicks.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst` is high, `reset_n_o` is 0 and `out_en_o` is 1. After power comes good, `reset_n_o` first reads 1 after clock edge number POR_TICKS+1, where POR_TICKS = UNIT_TICKS*POR_HALF_UNITS/2 and edge 1 is the first edge that samples `pwr_good_i` high. This assumes `wd_in_window_i` is 1.
- R2: A low level on `pwr_good_i` that lasts fewer than DEGLITCH_TICKS consecutive edges has no effect on `reset_n_o`. A low level that lasts DEGLITCH_TICKS or more edges drives `reset_n_o` to 0 one edge after the DEGLITCH_TICKS-th low sample.
- R3: After a filtered undervoltage, the delay restarts in full: `reset_n_o` first reads 1 after edge POR_TICKS+1, counting the first edge that samples `pwr_good_i` high again as edge 1. Reset is released only when power is good, the delay has elapsed and `wd_in_window_i` is 1. If the window flag is low once the delay has elapsed, reset stays low and is released one edge after the flag goes high.
- R4: In normal operation, with `enable_i` high, `wd_fault_i` = 1 drives `reset_n_o` low at the next edge. Reset then alternates between low and high phases of exactly UNIT_TICKS cycles each, starting with a low phase. It returns to a steady 1 one edge after `wd_in_window_i` = 1 with `wd_fault_i` = 0.
- R5: `out_en_o` stays 1 while enable is high, including while the pulse train runs. It also stays 1 while enable is low and the watchdog is normal.
- R6: In normal operation or during the pulse train, if the synchronized enable is 0 and `wd_fault_i` = 1, the block enters sleep at the next edge, with `out_en_o` = 0 and `reset_n_o` = 0. In sleep, the watchdog flags and `pwr_good_i` have no effect on either output.
- R7: A rising edge on `enable_i` in sleep sets `out_en_o` to 1 after edge SYNC_STAGES+1, counted from the change, and starts a full power-on delay. `reset_n_o` first reads 1 after edge POR_TICKS+SYNC_STAGES+1.
- R8: `enable_i` passes through SYNC_STAGES flip-flops before use. A change on it affects the sleep decision no earlier than edge SYNC_STAGES+1 after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Output-voltage comparator result, 1 when in regulation |
| enable_i | input | 1 | Asynchronous enable line, keeps the output on when high |
| wd_in_window_i | input | 1 | Watchdog period monitor: kicks are within window |
| wd_fault_i | input | 1 | Watchdog period monitor: too slow, too fast or stuck |
| reset_n_o | output | 1 | Active-low processor reset |
| out_en_o | output | 1 | Regulator output stage enable |

## Verification
The bound checker watches, on every cycle, the relations that hold in every state. Reset is low whenever the output stage is off. A filtered undervoltage always pulls reset low. The filter never fires before DEGLITCH_TICKS consecutive low samples. The output only turns off on a registered fault with the synchronized enable low. A wake-up always starts with reset low. Reset only rises with the window flag present or within the pulse train. The exact lengths — the power-on delay, the pulse phases, the dip threshold, the synchronizer latency and the wake-up sequence — come from the bench's directed scenarios, which count edges from each stimulus.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_POR     = 2'd0,
        ST_RUN     = 2'd1,
        ST_WDPULSE = 2'd2,
        ST_SLEEP   = 2'd3
    } sup_state_e;

    typedef struct packed {
        logic rst_n;
        logic out_en;
    } sup_out_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sup_en_sync.sv
module sup_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= async_i;
            end
            assign sync_o = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], async_i};
            end
            assign sync_o = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sup_uv_filter.sv
module sup_uv_filter #(
    parameter int DEG_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_i,
    output logic uv_o
);
    import sup_pkg::*;

    localparam int CW = width_for(DEG_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DEG_TICKS - 1);

    logic [CW-1:0] low_cnt;
    logic          uv_q;

    // Power is treated as bad until the first good sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            uv_q    <= 1'b1;
        end else if (!pwr_good_i) begin
            if (low_cnt == LAST) uv_q    <= 1'b1;
            else                 low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
            uv_q    <= 1'b0;
        end
    end

    assign uv_o = uv_q;
endmodule

// File: rtl/sup_tick_timer.sv
module sup_tick_timer #(
    parameter int W        = 8,
    parameter int INIT_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= W'(INIT_VAL);
        else if (load_i)      cnt <= load_val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done_o = (cnt == '0);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int UNIT_TICKS     = 100,
    parameter int POR_HALF_UNITS = 95,
    parameter int DEGLITCH_TICKS = 20,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_i,
    input  logic enable_i,
    input  logic wd_in_window_i,
    input  logic wd_fault_i,
    output logic reset_n_o,
    output logic out_en_o
);
    import sup_pkg::*;

    localparam int POR_TICKS = (UNIT_TICKS * POR_HALF_UNITS) / 2;
    localparam int TW        = width_for(max_i(POR_TICKS, UNIT_TICKS));
    localparam logic [TW-1:0] POR_LOAD  = TW'(POR_TICKS - 1);
    localparam logic [TW-1:0] UNIT_LOAD = TW'(UNIT_TICKS - 1);

    logic       en_s;
    logic       en_prev;
    logic       uv_flt;
    logic       t_done;
    logic       t_load;
    logic [TW-1:0] t_val;

    sup_state_e st_q, st_d;
    logic       ph_q, ph_d;
    sup_out_t   outs;

    sup_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (enable_i),
        .sync_o  (en_s)
    );

    sup_uv_filter #(.DEG_TICKS(DEGLITCH_TICKS)) u_uv (
        .clk        (clk),
        .rst        (rst),
        .pwr_good_i (pwr_good_i),
        .uv_o       (uv_flt)
    );

    sup_tick_timer #(.W(TW), .INIT_VAL(POR_TICKS - 1)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (t_load),
        .load_val_i (t_val),
        .done_o     (t_done)
    );

    // Next-state logic; sleep is judged only on registered inputs.
    always_comb begin
        st_d   = st_q;
        ph_d   = ph_q;
        t_load = 1'b0;
        t_val  = UNIT_LOAD;
        unique case (st_q)
            ST_POR: begin
                if (uv_flt) begin
                    t_load = 1'b1;
                    t_val  = POR_LOAD;
                end else if (t_done && wd_in_window_i) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (uv_flt) begin
                    st_d   = ST_POR;
                    t_load = 1'b1;
                    t_val  = POR_LOAD;
                end else if (wd_fault_i) begin
                    if (!en_s) begin
                        st_d = ST_SLEEP;
                    end else begin
                        st_d   = ST_WDPULSE;
                        ph_d   = 1'b0;
                        t_load = 1'b1;
                    end
                end
            end
            ST_WDPULSE: begin
                if (uv_flt) begin
                    st_d   = ST_POR;
                    t_load = 1'b1;
                    t_val  = POR_LOAD;
                end else if (wd_fault_i && !en_s) begin
                    st_d = ST_SLEEP;
                end else if (wd_in_window_i && !wd_fault_i) begin
                    st_d = ST_RUN;
                end else if (t_done) begin
                    ph_d   = ~ph_q;
                    t_load = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (en_s && !en_prev) begin
                    st_d   = ST_POR;
                    t_load = 1'b1;
                    t_val  = POR_LOAD;
                end
            end
            default: st_d = ST_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_POR;
            ph_q    <= 1'b0;
            en_prev <= 1'b0;
        end else begin
            st_q    <= st_d;
            ph_q    <= ph_d;
            en_prev <= en_s;
        end
    end

    always_comb begin
        outs.rst_n  = (st_q == ST_RUN) || ((st_q == ST_WDPULSE) && ph_q);
        outs.out_en = (st_q != ST_SLEEP);
    end

    assign reset_n_o = outs.rst_n;
    assign out_en_o  = outs.out_en;

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int DEG_TICKS = 20
) (
    input logic               clk,
    input logic               rst,
    input logic               pwr_good_i,
    input logic               wd_in_window_i,
    input logic               wd_fault_i,
    input logic               reset_n_o,
    input logic               out_en_o,
    input logic               uv_flt,
    input logic               en_s,
    input sup_pkg::sup_state_e st_q
);
    import sup_pkg::*;

    localparam int LW = width_for(DEG_TICKS);
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                          low_run <= '0;
        else if (pwr_good_i)              low_run <= '0;
        else if (low_run != LW'(DEG_TICKS)) low_run <= low_run + 1'b1;
    end

    // R6
    off_holds_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en_o |-> !reset_n_o);

    // R2
    uv_pulls_reset_chk: assert property (@(posedge clk) disable iff (rst)
        uv_flt |=> !reset_n_o);

    // R2
    deglitch_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(uv_flt) |-> (low_run >= LW'(DEG_TICKS)));

    // R8
    sleep_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_en_o) |-> ($past(wd_fault_i) && !$past(en_s)));

    // R7
    wake_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en_o) |-> !reset_n_o);

    // R3
    release_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n_o) |-> ($past(wd_in_window_i) || ($past(st_q) == ST_WDPULSE)));

endmodule

bind supply_supervisor sup_checker #(.DEG_TICKS(DEGLITCH_TICKS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pwr_good_i     (pwr_good_i),
    .wd_in_window_i (wd_in_window_i),
    .wd_fault_i     (wd_fault_i),
    .reset_n_o      (reset_n_o),
    .out_en_o       (out_en_o),
    .uv_flt         (uv_flt),
    .en_s           (en_s),
    .st_q           (st_q)
);

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT  = 4;
    localparam int HALF  = 95;
    localparam int DEG   = 3;
    localparam int SYNC  = 2;
    localparam int NPOR  = (UNIT * HALF) / 2;

    // Each entry: {dip length in edges [8:1], reset expected [0]}
    localparam logic [8:0] DIP_VEC [5] = '{
        {8'd1, 1'b0}, {8'd2, 1'b0}, {8'd3, 1'b1}, {8'd6, 1'b1}, {8'd2, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, pg, en, wok, wflt;
    logic rn, oen;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_supervisor #(
        .UNIT_TICKS(UNIT), .POR_HALF_UNITS(HALF),
        .DEGLITCH_TICKS(DEG), .SYNC_STAGES(SYNC)
    ) uut (
        .clk(clk), .rst(rst), .pwr_good_i(pg), .enable_i(en),
        .wd_in_window_i(wok), .wd_fault_i(wflt),
        .reset_n_o(rn), .out_en_o(oen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic edges_to_rise(output int n, input int lim);
        n = 0;
        do begin
            step();
            n++;
        end while (!rn && n < lim);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (rn == lvl && n < 4 * UNIT);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1; pg = 0; en = 1; wok = 1; wflt = 0;
        repeat (3) step();
        // R1 reset state
        chk(rn == 0, "R1 reset_n in reset", rn, 0);
        chk(oen == 1, "R1 out_en in reset", oen, 1);
        rst = 0;
        repeat (5) step();
        chk(rn == 0, "R1 held while power bad", rn, 0);

        // R1 power-on delay
        pg = 1;
        edges_to_rise(n, NPOR + 20);
        chk(n == NPOR + 1, "R1 power-on delay", n, NPOR + 1);

        // R2/R3 dip table
        for (int i = 0; i < 5; i++) begin
            int dip;
            bit exp_rst, seen;
            dip = int'(DIP_VEC[i][8:1]);
            exp_rst = DIP_VEC[i][0];
            seen = 0;
            repeat (3) step();
            pg = 0;
            for (int k = 0; k < dip; k++) begin
                step();
                if (!rn) seen = 1;
            end
            pg = 1;
            n = 0;
            for (int k = 0; k < NPOR + 20; k++) begin
                step();
                n++;
                if (!rn) seen = 1;
                if (rn && seen) break;
                if (!exp_rst && k > 10) break;
            end
            chk(seen == exp_rst, "R2 dip response", seen, exp_rst);
            if (exp_rst)
                chk(n == NPOR + 1, "R3 delay restart", n, NPOR + 1);
        end

        // R3 release waits for watchdog window
        wok = 0;
        pg = 0;
        repeat (4) step();
        pg = 1;
        repeat (NPOR + 10) step();
        chk(rn == 0, "R3 held without window", rn, 0);
        wok = 1;
        step();
        chk(rn == 1, "R3 release on window", rn, 1);

        // R4 pulse train with enable high
        repeat (3) step();
        wok = 0; wflt = 1;
        step();
        chk(rn == 0, "R4 first low", rn, 0);
        run_len(1'b0, n);
        chk(n == UNIT, "R4 low phase length", n, UNIT);
        run_len(1'b1, n);
        chk(n == UNIT, "R4 high phase length", n, UNIT);
        chk(oen == 1, "R5 output on during train", oen, 1);
        run_len(1'b0, n);
        chk(n == UNIT, "R4 second low phase", n, UNIT);
        wok = 1; wflt = 0;
        step();
        chk(rn == 1, "R4 recovery", rn, 1);
        repeat (2 * UNIT) step();
        chk(rn == 1, "R4 stays released", rn, 1);

        // R8 synchronizer latency on sleep entry from pulse train
        wok = 0; wflt = 1;
        step();
        step();
        en = 0;
        for (int k = 1; k <= SYNC; k++) begin
            step();
            chk(oen == 1, "R8 before sync latency", oen, 1);
        end
        step();
        chk(oen == 0, "R8/R6 sleep after sync", oen, 0);
        chk(rn == 0, "R6 reset low in sleep", rn, 0);

        // R6 sleep ignores watchdog and power
        wflt = 0; wok = 1;
        pg = 0;
        repeat (6) step();
        pg = 1;
        repeat (6) step();
        chk(oen == 0, "R6 sleep ignores inputs", oen, 0);
        chk(rn == 0, "R6 reset stays low", rn, 0);

        // R7 wake on rising enable
        en = 1;
        n = 0;
        for (int k = 0; k < NPOR + SYNC + 20; k++) begin
            step();
            n++;
            if (n == SYNC + 1) begin
                chk(oen == 1, "R7 output on at wake", oen, 1);
                chk(rn == 0, "R7 reset low at wake", rn, 0);
            end
            if (rn) break;
        end
        chk(n == NPOR + SYNC + 1, "R7 wake delay", n, NPOR + SYNC + 1);

        // R5 enable low with watchdog normal
        en = 0;
        repeat (10) step();
        chk(oen == 1, "R5 output on with enable low", oen, 1);
        chk(rn == 1, "R5 reset released", rn, 1);

        // R6 sleep from normal operation
        wflt = 1; wok = 0;
        step();
        chk(oen == 0, "R6 sleep from run", oen, 0);
        chk(rn == 0, "R6 reset low entering sleep", rn, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule